// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block is the interrupt endpoint of one agent in a multi-agent system. Eleven channels share one 32-bit register word at scattered bit positions: 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 (valid-bit mask 0x0F0F0301). Software on the local agent can pulse outbound trigger lines toward other agents. It also sees inbound requests from those agents latch into a sticky status word, and it selects which channels may raise its single interrupt line.

Software reaches the block through a minimal synchronous register port. The port has a write strobe, a byte address and write data, and read data is combinational from the address. Inside the block each register is held in compacted form, one bit per channel. It is spread back onto the sparse positions when read. The mask register cannot be written directly. It changes only through a pair of write-only ports: one clears mask bits and the other sets them. A read-only observation word mirrors a set of per-channel observation inputs.

Top module: `ipi_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it, the status word reads 0, the mask word reads 0x0F0F0301, `trig_out`, `obs_out` and `irq` are 0, and `req_in` has no effect.
- R2: A write to offset 0x00 drives `trig_out[k]` high for exactly the one cycle after the write edge, for each channel k whose bit is 1 in the written word. Channel k sits at bit position k-th of {0,8,9,16,17,18,19,24,25,26,27}. Offset 0x00 always reads 0.
- R3: `req_in[k]` high at a rising edge sets status bit k (offset 0x10). The bit stays set until a write to 0x10 carries 1 at that channel's position. Writing 0 there leaves it set.
- R4: If a request and a write-one-to-clear hit the same status bit at the same edge, the bit ends up set.
- R5: `obs_out[k]` always equals status bit k.
- R6: Writing 1s to offset 0x18 clears the matching bits of the mask word (offset 0x14). Writing 1s to offset 0x1C sets them. Writes to 0x14 are ignored, and offsets 0x18 and 0x1C read 0.
- R7: `irq` is high exactly when some channel has its status bit set and its mask bit clear. It follows the registered state with no extra delay.
- R8: The observation word (offset 0x04) shows, at each channel position, the level `obs_in[k]` had at the most recent rising edge.
- R9: Reserved bit positions (outside 0x0F0F0301) read 0 and have no effect when written. Unmapped or misaligned offsets (for example 0x08, 0x20, 0x11) read 0, and writes to them change nothing.
- R10: Writes to offset 0x04 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_in | input | 11 | Inbound request per channel, sampled each edge |
| obs_in | input | 11 | Observation level per channel |
| trig_out | output | 11 | Outbound one-cycle trigger per channel |
| obs_out | output | 11 | Per-channel copy of the status word |
| irq | output | 1 | Level interrupt to the local agent |

## Verification
The hardest case to reach from the ports is a request and a write-one-to-clear landing on the same status bit at the same edge. The bench drives the inbound line and the status-register write in the same low clock phase, so that both are sampled by one edge. The random phase produces the same collision again with scattered written words and request patterns. Between steps it reads back every register, including words that carry reserved bits.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] OFF_TRIG = 8'h00;
  localparam logic [7:0] OFF_OBS  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_MASK = 8'h14;
  localparam logic [7:0] OFF_EN   = 8'h18;
  localparam logic [7:0] OFF_DIS  = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TRIG, SEL_OBS, SEL_STAT, SEL_MASK, SEL_EN, SEL_DIS
  } reg_sel_e;

  // Number of set bits in a channel map.
  function automatic int chan_count(input logic [WORD_W-1:0] map);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) if (map[i]) n++;
    return n;
  endfunction

  // Gather the mapped bit positions of a bus word into a dense vector.
  function automatic logic [WORD_W-1:0] pack_bits(input logic [WORD_W-1:0] w,
                                                  input logic [WORD_W-1:0] map);
    logic [WORD_W-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (map[i]) begin
        r[j] = w[i];
        j++;
      end
    end
    return r;
  endfunction

  // Scatter a dense vector back onto the mapped bit positions.
  function automatic logic [WORD_W-1:0] unpack_bits(input logic [WORD_W-1:0] c,
                                                    input logic [WORD_W-1:0] map);
    logic [WORD_W-1:0] r;
    int j;
    r = '0;
    j = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (map[i]) begin
        r[i] = c[j];
        j++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_trig,
  output logic              wr_stat,
  output logic              wr_en,
  output logic              wr_dis
);

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_TRIG): sel = SEL_TRIG;
      ADDR_W'(OFF_OBS):  sel = SEL_OBS;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      ADDR_W'(OFF_MASK): sel = SEL_MASK;
      ADDR_W'(OFF_EN):   sel = SEL_EN;
      ADDR_W'(OFF_DIS):  sel = SEL_DIS;
      default:           sel = SEL_NONE;
    endcase
  end

  // Only the four writable registers get strobes; observation and mask
  // writes, and unmapped offsets, have no strobe at all.
  assign wr_trig = bus_we && (sel == SEL_TRIG);
  assign wr_stat = bus_we && (sel == SEL_STAT);
  assign wr_en   = bus_we && (sel == SEL_EN);
  assign wr_dis  = bus_we && (sel == SEL_DIS);

endmodule

// File: rtl/ipi_trig_gen.sv
module ipi_trig_gen #(
  parameter int NCH = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_trig,
  input  logic [NCH-1:0] trig_bits,
  output logic [NCH-1:0] trig_out
);

  logic [NCH-1:0] pulse_q;

  // The register self-clears: it holds written bits for one cycle only.
  always_ff @(posedge clk) begin
    if (!rst_n)       pulse_q <= '0;
    else if (wr_trig) pulse_q <= trig_bits;
    else              pulse_q <= '0;
  end

  assign trig_out = pulse_q;

  p_trig_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_out) |-> $past(wr_trig));

endmodule

// File: rtl/ipi_status_bank.sv
module ipi_status_bank #(
  parameter int NCH = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_in,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] obs_in,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] obs_seen
);

  logic [NCH-1:0] stat_q;
  logic [NCH-1:0] obs_q;

  // Clear first, then set: a coincident request survives the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      obs_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | req_in;
      obs_q  <= obs_in;
    end
  end

  assign status   = stat_q;
  assign obs_seen = obs_q;

  p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_bits) & ~stat_q) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(req_in)) == $past(req_in)));

endmodule

// File: rtl/ipi_mask_bank.sv
module ipi_mask_bank #(
  parameter int NCH = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_dis,
  input  logic [NCH-1:0] sel_bits,
  output logic [NCH-1:0] mask
);

  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] unmask_bits;
  logic [NCH-1:0] remask_bits;

  assign unmask_bits = wr_en  ? sel_bits : '0;
  assign remask_bits = wr_dis ? sel_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= (mask_q & ~unmask_bits) | remask_bits;
  end

  assign mask = mask_q;

  p_mask_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wr_dis) |=> $stable(mask_q));

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter logic [31:0] CH_MAP = 32'h0F0F_0301,
  parameter int          ADDR_W = 8,
  localparam int         NCH    = chan_count(CH_MAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    req_in,
  input  logic [NCH-1:0]    obs_in,
  output logic [NCH-1:0]    trig_out,
  output logic [NCH-1:0]    obs_out,
  output logic              irq
);

  reg_sel_e       sel;
  logic           wr_trig, wr_stat, wr_en, wr_dis;
  logic [31:0]    wdata_packed;
  logic [NCH-1:0] chan_bits;
  logic [NCH-1:0] clr_bits;
  logic [NCH-1:0] status;
  logic [NCH-1:0] obs_seen;
  logic [NCH-1:0] mask;
  logic [NCH-1:0] pending;

  ipi_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .sel     (sel),
    .wr_trig (wr_trig),
    .wr_stat (wr_stat),
    .wr_en   (wr_en),
    .wr_dis  (wr_dis)
  );

  // Reserved positions drop out when the write word is packed.
  assign wdata_packed = pack_bits(bus_wdata, CH_MAP);
  assign chan_bits    = wdata_packed[NCH-1:0];
  assign clr_bits     = wr_stat ? chan_bits : '0;

  ipi_trig_gen #(.NCH(NCH)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_trig  (wr_trig),
    .trig_bits(chan_bits),
    .trig_out (trig_out)
  );

  ipi_status_bank #(.NCH(NCH)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_in),
    .clr_bits(clr_bits),
    .obs_in  (obs_in),
    .status  (status),
    .obs_seen(obs_seen)
  );

  ipi_mask_bank #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_dis  (wr_dis),
    .sel_bits(chan_bits),
    .mask    (mask)
  );

  assign pending = status & ~mask;
  assign irq     = |pending;
  assign obs_out = status;

  // Trigger, enable and disable read as zero through the default arm.
  always_comb begin
    case (sel)
      SEL_OBS:  bus_rdata = unpack_bits(32'(obs_seen), CH_MAP);
      SEL_STAT: bus_rdata = unpack_bits(32'(status), CH_MAP);
      SEL_MASK: bus_rdata = unpack_bits(32'(mask), CH_MAP);
      default:  bus_rdata = '0;
    endcase
  end

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);

  p_irq_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

endmodule

// File: tb/tb_ipi_ctrl.sv
`timescale 1ns/1ps
module tb_ipi_ctrl;

  localparam int    NCH = 11;
  localparam time   TCK = 20ns;
  localparam logic [31:0] VALID = 32'h0F0F_0301;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic [7:0]     bus_addr = 8'h00;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] req_in = '0;
  logic [NCH-1:0] obs_in = '0;
  logic [NCH-1:0] trig_out;
  logic [NCH-1:0] obs_out;
  logic           irq;

  int n_checks = 0;
  int n_fail = 0;

  int unsigned pos_tbl [NCH] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

  logic [NCH-1:0] m_stat, m_mask, m_obs, m_trig;

  always #(TCK/2) clk = ~clk;

  ipi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in),
    .obs_in(obs_in), .trig_out(trig_out), .obs_out(obs_out), .irq(irq)
  );

  function automatic logic [NCH-1:0] to_chan(input logic [31:0] w);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) r[k] = w[pos_tbl[k]];
    return r;
  endfunction

  function automatic logic [31:0] to_word(input logic [NCH-1:0] c);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < NCH; k++) r[pos_tbl[k]] = c[k];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_we   = 1'b0;
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Drive one cycle in the low phase, let one rising edge pass, update model.
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                      input logic [NCH-1:0] rq, input logic [NCH-1:0] ob);
    logic [NCH-1:0] sel;
    bus_we = we; bus_addr = a; bus_wdata = wd; req_in = rq; obs_in = ob;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    sel = to_chan(wd);
    m_trig = (we && a == 8'h00) ? sel : '0;
    if (we && a == 8'h10) m_stat = m_stat & ~sel;
    m_stat = m_stat | rq;
    if (we && a == 8'h18) m_mask = m_mask & ~sel;
    if (we && a == 8'h1C) m_mask = m_mask | sel;
    m_obs = ob;
  endtask

  task automatic check_all();
    logic [31:0] d;
    check("R2 trig_out", 32'(trig_out), 32'(m_trig));
    check("R5 obs_out", 32'(obs_out), 32'(m_stat));
    check("R7 irq", 32'(irq), 32'(|(m_stat & ~m_mask)));
    rd(8'h10, d); check("R3 status read", d, to_word(m_stat));
    rd(8'h14, d); check("R6 mask read", d, to_word(m_mask));
    rd(8'h04, d); check("R8 obs read", d, to_word(m_obs));
    rd(8'h00, d); check("R2 trig reads zero", d, 32'h0);
    rd(8'h18, d); check("R6 enable reads zero", d, 32'h0);
    rd(8'h1C, d); check("R6 disable reads zero", d, 32'h0);
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    m_stat = '0; m_mask = '1; m_obs = '0; m_trig = '0;

    // R1: reset with requests held high
    req_in = '1; obs_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset trig_out", 32'(trig_out), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
    check("R1 reset obs_out", 32'(obs_out), 32'h0);
    rd(8'h10, d); check("R1 reset status", d, 32'h0);
    rd(8'h14, d); check("R1 reset mask", d, VALID);
    req_in = '0; obs_in = '0;
    rst_n = 1'b1;
    step(1'b0, 8'h00, 32'h0, '0, '0);
    check_all();

    // R3: request latches, masked so no interrupt
    step(1'b0, 8'h00, 32'h0, 11'b000_0000_0001, '0); check_all();
    step(1'b0, 8'h00, 32'h0, '0, '0); check_all();
    // R6/R7: unmask all, interrupt rises
    step(1'b1, 8'h18, 32'hFFFF_FFFF, '0, '0); check_all();
    check("R7 irq after unmask", 32'(irq), 32'h1);
    // R3: writing zero leaves the bit, writing one clears it
    step(1'b1, 8'h10, 32'h0, '0, '0); check_all();
    step(1'b1, 8'h10, 32'h0000_0001, '0, '0); check_all();
    check("R3 cleared irq", 32'(irq), 32'h0);
    // R4: request and clear on the same bit at the same edge
    step(1'b1, 8'h10, 32'h0001_0000, 11'b000_0000_1000, '0);
    rd(8'h10, d); check("R4 set wins", d, 32'h0001_0000);
    check_all();
    // R9: reserved trigger bits do nothing; R2: all channels pulse once
    step(1'b1, 8'h00, 32'hF0F0_FCFE, '0, '0);
    check("R9 reserved trig", 32'(trig_out), 32'h0);
    check_all();
    step(1'b1, 8'h00, VALID, '0, '0);
    check("R2 all pulse", 32'(trig_out), 32'h7FF);
    step(1'b0, 8'h00, 32'h0, '0, '0);
    check("R2 pulse ends", 32'(trig_out), 32'h0);
    check_all();
    // R6: direct mask write ignored; disable sets bits
    step(1'b1, 8'h14, 32'hFFFF_FFFF, '0, '0); check_all();
    step(1'b1, 8'h1C, 32'h0001_0100, '0, '0); check_all();
    // R10: write to observation register ignored; R8 follows inputs
    step(1'b1, 8'h04, 32'hFFFF_FFFF, '0, 11'b101_0101_0101); check_all();
    // R9: unmapped and misaligned accesses
    step(1'b1, 8'h08, 32'hFFFF_FFFF, '0, '0); check_all();
    step(1'b1, 8'h11, 32'hFFFF_FFFF, '0, '0); check_all();
    step(1'b1, 8'h20, 32'hFFFF_FFFF, '0, '0); check_all();
    rd(8'h08, d); check("R9 unmapped 08 reads zero", d, 32'h0);
    rd(8'h11, d); check("R9 misaligned 11 reads zero", d, 32'h0);
    rd(8'h20, d); check("R9 unmapped 20 reads zero", d, 32'h0);
    rd(8'h10, d); check("R9 reserved status bits zero", d & ~VALID, 32'h0);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      logic [7:0] a;
      logic [NCH-1:0] rq;
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: a = 8'h00;
        1: a = 8'h10;
        2: a = 8'h18;
        3: a = 8'h1C;
        4: a = 8'h14;
        5: a = 8'h04;
        6: a = 8'(4 * $urandom_range(0, 15) + $urandom_range(0, 3));
        default: a = 8'h10;
      endcase
      rq = NCH'($urandom & $urandom & $urandom);
      step(($urandom_range(0, 3) != 0), a, $urandom, rq, NCH'($urandom));
      check_all();
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule